// File: doc/BRIEF.md
# Level-Tracking Masked Interrupt Controller

The block gathers a vector of level-sensitive interrupt request lines from peripheral sources and merges them into one request toward the processor. Each line is brought into the block's clock domain through a two-flop synchronizer. The synchronized vector is the pending register. That register is never latched: a pending bit stays set only while its source holds the line high, and it clears once the source lets go. Software has no way to clear it. A software-written enable mask selects which pending bits may raise the processor request. The request output is a flop loaded with the OR of the masked pending bits.

Software reaches the block through a word-only register port. A request is offered with `req_valid` and is always accepted, because `req_ready` is tied high and there is no back-pressure. A read returns its data one cycle later, with `rsp_valid` high for exactly one cycle. The response path has no ready signal, so the requester must take the data on that cycle. A write produces no response. Two control offsets accept writes and discard them. Every other offset reads as zero and ignores writes.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Each pending bit equals its input line as sampled two clock edges earlier (two-flop synchronizer), so it is set while the line is high and cleared once the line goes low.
- R2: `irq_out` is a registered signal: at each clock edge it loads 1 if the bitwise AND of the mask and the pending register is nonzero, and 0 otherwise. It therefore reflects a mask or pending change one clock later.
- R3: A write at byte offset 0x04 replaces every bit of the mask with `req_wdata`, and a read at 0x04 returns the mask.
- R4: A read at byte offset 0x0C returns the pending register value at the accepting edge.
- R5: Writes at byte offsets 0x00 and 0x14 are accepted but change neither the mask nor `irq_out`.
- R6: Any offset other than 0x04 and 0x0C reads as zero, and any write there other than at 0x04 is ignored. Addresses whose two low bits are not zero count as unlisted offsets.
- R7: Reset (`rst_n` low) clears the mask, the pending register, `irq_out` and `rsp_valid`.
- R8: `req_ready` is always high. A read accepted at one edge raises `rsp_valid` with its data for the following cycle only, and writes raise no response.
- R9: Software cannot clear the pending register: a write to 0x0C leaves the pending value unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | N_LINES (32) | Level-sensitive request lines, asynchronous |
| req_valid | input | 1 | Register request offered |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte offset of the register |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | DATA_W (32) | Read data |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Two changes can land on the same clock edge: a mask write, and a pending bit changing as the synchronizer output moves. The bench provokes this by writing the mask to enable a line that is already pending, in the same cycle that line is dropped. A registered output reading the new mask and the still-set pending bit must then give a one-cycle pulse on `irq_out`, and the bench checks the output cycle by cycle. It also issues a pending read while lines change, and judges the result against the value synchronized at the accepting edge.

// File: rtl/lvlirq_pkg.sv
package lvlirq_pkg;

  localparam logic [31:0] OFS_ROUTE = 32'h0000_0000;
  localparam logic [31:0] OFS_MASK  = 32'h0000_0004;
  localparam logic [31:0] OFS_PEND  = 32'h0000_000C;
  localparam logic [31:0] OFS_CTRL  = 32'h0000_0014;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ROUTE,
    SEL_MASK,
    SEL_PEND,
    SEL_CTRL
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [31:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_ROUTE: s = SEL_ROUTE;
      OFS_MASK:  s = SEL_MASK;
      OFS_PEND:  s = SEL_PEND;
      OFS_CTRL:  s = SEL_CTRL;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines_async,
  output logic [N_LINES-1:0] pend
);

  logic [N_LINES-1:0] stage1;

  for (genvar i = 0; i < N_LINES; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[i] <= 1'b0;
        pend[i]   <= 1'b0;
      end else begin
        stage1[i] <= lines_async[i];
        pend[i]   <= stage1[i];
      end
    end
  end

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  // R1
  pend_follows_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (pend == $past(lines_async, 2)));

endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import lvlirq_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [N_LINES-1:0] pend,
  output logic [N_LINES-1:0] mask,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data
);

  function automatic logic [DATA_W-1:0] widen(input logic [N_LINES-1:0] v);
    logic [DATA_W-1:0] t;
    t = '0;
    t[N_LINES-1:0] = v;
    return t;
  endfunction

  reg_sel_e sel;
  logic     do_rd;
  logic     do_wr_mask;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    sel        = decode_offset(32'(req_addr));
    do_rd      = req_valid && !req_write;
    do_wr_mask = req_valid && req_write && (sel == SEL_MASK);
    case (sel)
      SEL_MASK: rd_mux = widen(mask);
      SEL_PEND: rd_mux = widen(pend);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mask <= '0;
    else if (do_wr_mask) mask <= req_wdata[N_LINES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= do_rd;
      if (do_rd) rsp_data <= rd_mux;
    end
  end

  // R3
  mask_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && 32'(req_addr) == OFS_MASK)
      |=> (mask == $past(req_wdata[N_LINES-1:0])));

  // R5
  other_write_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && 32'(req_addr) != OFS_MASK) |=> $stable(mask));

  // R6
  unlisted_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && 32'(req_addr) != OFS_MASK && 32'(req_addr) != OFS_PEND)
      |=> (rsp_valid && rsp_data == '0));

  // R8
  rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rsp_valid == $past(req_valid && !req_write)));

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] mask,
  input  logic [N_LINES-1:0] pend,
  output logic               irq_q
);

  logic any_live;
  assign any_live = |(mask & pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_live;
  end

  // R2
  irq_one_cycle_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_q == ($past(mask & pend) != '0)));

  // R2
  irq_needs_enabled_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask) == '0) |-> !irq_q);

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int N_LINES = 32,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               irq_out
);

  logic [N_LINES-1:0] pend;
  logic [N_LINES-1:0] mask;

  assign req_ready = 1'b1;

  irq_line_sync #(.N_LINES(N_LINES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .lines_async (irq_lines),
    .pend        (pend)
  );

  irq_reg_port #(.N_LINES(N_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .pend      (pend),
    .mask      (mask),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  irq_out_stage #(.N_LINES(N_LINES)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .mask  (mask),
    .pend  (pend),
    .irq_q (irq_out)
  );

  // R7
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!irq_out && !rsp_valid));

endmodule

// File: tb/lvl_irq_ctrl_test.sv
module lvl_irq_ctrl_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lvl_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: read request, expectation pushed to the scoreboard
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // monitor: pops the scoreboard whenever a response appears
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected response", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), rsp_data, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 irq_out in reset", {31'd0, irq_out}, 32'd0);
    check("R7 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 req_ready high", {31'd0, req_ready}, 32'd1);
    rd(8'h04, 32'h0, "R7 mask after reset");
    rd(8'h0C, 32'h0, "R7 pending after reset");

    wr(8'h04, 32'hA5A5_0F0F);
    rd(8'h04, 32'hA5A5_0F0F, "R3 mask readback A5A50F0F");
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'hFFFF_FFFF, "R3 mask readback all ones");
    wr(8'h04, 32'h0);

    irq_lines = 32'h0000_1234;
    settle();
    rd(8'h0C, 32'h0000_1234, "R4 pending 1234");
    check("R2 irq low with mask zero", {31'd0, irq_out}, 32'd0);
    irq_lines = 32'h0000_0004;
    settle();
    rd(8'h0C, 32'h0000_0004, "R1 pending follows fall");

    wr(8'h04, 32'h0000_0004);
    check("R2 irq one cycle after mask write (old)", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R2 irq one cycle after mask write (new)", {31'd0, irq_out}, 32'd1);

    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h14, 32'h0000_0000);
    rd(8'h04, 32'h0000_0004, "R5 mask kept after control writes");
    check("R5 irq kept after control writes", {31'd0, irq_out}, 32'd1);

    wr(8'h0C, 32'h0);
    rd(8'h0C, 32'h0000_0004, "R9 pending not cleared by write");

    rd(8'h08, 32'h0, "R6 read 08 zero");
    rd(8'h10, 32'h0, "R6 read 10 zero");
    rd(8'h05, 32'h0, "R6 misaligned read zero");
    rd(8'h00, 32'h0, "R6 read 00 zero");
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h06, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0000_0004, "R6 unlisted writes ignored");

    // R1 latency: line rises, irq two sync edges plus one output edge later
    wr(8'h04, 32'h0000_0100);
    irq_lines = 32'h0;
    settle();
    check("R2 irq low with no pending", {31'd0, irq_out}, 32'd0);
    irq_lines = 32'h0000_0100;
    @(negedge clk);
    check("R1 latency edge1", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R1 latency edge2", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R1 latency edge3", {31'd0, irq_out}, 32'd1);
    irq_lines = 32'h0;
    settle();
    check("R1 irq falls with line", {31'd0, irq_out}, 32'd0);

    // same cycle: enable bit 3 while line 3 drops
    wr(8'h04, 32'h0);
    irq_lines = 32'h0000_0008;
    settle();
    check("R2 masked line gives no irq", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h04; req_wdata = 32'h0000_0008;
    irq_lines = 32'h0;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R2 overlap after edge1", {31'd0, irq_out}, 32'd0);
    @(negedge clk);
    check("R2 overlap pulse after edge2", {31'd0, irq_out}, 32'd1);
    @(negedge clk);
    check("R2 overlap after edge3", {31'd0, irq_out}, 32'd0);

    // pending read while the line moves: accepting edge sees the old value
    irq_lines = 32'h8000_0001;
    settle();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h0C;
    exp_q.push_back(32'h8000_0001); tag_q.push_back("R4 read during line change");
    irq_lines = 32'h0;
    @(negedge clk);
    req_valid = 1'b0;

    repeat (4) @(negedge clk);
    check("R8 scoreboard drained", exp_q.size(), 32'd0);
    finish_run();
  end

endmodule